// File: doc/BRIEF.md
# PHY Power-Down Decision Logic

This block decides, for one network port, whether its PHY and MAC may be switched off, and issues registered power-down requests toward the power controller. The PHY stays powered for as long as any client still needs the link: the function in full power, wake-on-LAN, the management controller, or PME wake signalling. It is switched off when the port is strapped to SerDes mode, when software disables the port, or when the external disable pin is asserted and a configuration bit lets that pin act. A disable that affects only the host-bus function leaves the PHY alone.

A request rises only after its condition has been sampled on two consecutive clock edges, so short glitches on the inputs are filtered out. It drops on the first edge after its condition goes away. After a release, no new PHY power-down is issued until the PHY acknowledges that it is powered up again. Until the configuration inputs are marked valid, both requests stay low.

Top module: `phy_pd_ctrl`

## Requirements
- R1: While `rst_n` is low, or while `cfg_valid` was low at the last clock edge, both `phy_pd_req` and `mac_pd_req` are 0.
- R2: With `cfg_lp_pd_en` = 1, `pwr_state` not 2'b00 (2'b00 is full power), and `wol_active`, `mng_uses_port` and `pme_en` all 0, the PHY is requested down.
- R3: A low-power power-down is not requested if `pwr_state` is 2'b00, if `cfg_lp_pd_en` is 0, or if any one of `wol_active`, `mng_uses_port` or `pme_en` is 1.
- R4: With `serdes_mode` = 1 the PHY is requested down, whatever the client inputs are.
- R5: An asserted `lan_off_pin` requests both PHY and MAC down if `cfg_pin_pd` = 1; if `cfg_pin_pd` = 0 the pin requests neither.
- R6: With `cfg_port_off` = 1 the PHY is requested down.
- R7: `cfg_bus_off` has no effect on either request.
- R8: A request rises only at the second of two consecutive clock edges at which its condition (and `cfg_valid`) held.
- R9: A request falls at the first clock edge at which its condition no longer holds.
- R10: While `phy_pd_req` is 0 and `phy_dn_ack` is 1 (PHY still reports powered down), `phy_pd_req` stays 0; once high, `phy_pd_req` does not depend on `phy_dn_ack`.
- R11: `mac_pd_req` is driven only by the qualified disable pin; SerDes mode, port disable and low-power conditions leave it at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_valid | input | 1 | Configuration inputs are loaded and valid |
| pwr_state | input | 2 | Function power state, 2'b00 = full power |
| wol_active | input | 1 | Wake-on-LAN is armed |
| mng_uses_port | input | 1 | Management controller uses this port |
| pme_en | input | 1 | PME wake signalling enabled |
| serdes_mode | input | 1 | Port is configured for SerDes |
| lan_off_pin | input | 1 | External disable pin, active high |
| cfg_lp_pd_en | input | 1 | Allow power-down in low-power states |
| cfg_pin_pd | input | 1 | Let the disable pin power down PHY and MAC |
| cfg_port_off | input | 1 | Port disabled by configuration |
| cfg_bus_off | input | 1 | Host-bus function disabled only |
| phy_dn_ack | input | 1 | PHY reports it is powered down |
| phy_pd_req | output | 1 | Registered PHY power-down request |
| mac_pd_req | output | 1 | Registered MAC power-down request |

## Verification
Directed patterns raise each power-down cause alone and then add each link client one at a time, which separates the low-power rule from the forced causes (SerDes, port disable, qualified pin) and shows that the bus-only disable and the unqualified pin do nothing. Timed checks one and two cycles after a change tell the two-edge filter from a one-edge path and the immediate release from a filtered one. Holding the acknowledge high across a release shows the re-arm lock, and random streams of toggled inputs with a random acknowledge then compare both requests every cycle against a bench model.

// File: rtl/phy_pd_ctrl.sv
module phy_pd_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_valid,
  input  logic [1:0] pwr_state,
  input  logic       wol_active,
  input  logic       mng_uses_port,
  input  logic       pme_en,
  input  logic       serdes_mode,
  input  logic       lan_off_pin,
  input  logic       cfg_lp_pd_en,
  input  logic       cfg_pin_pd,
  input  logic       cfg_port_off,
  input  logic       cfg_bus_off,
  input  logic       phy_dn_ack,
  output logic       phy_pd_req,
  output logic       mac_pd_req
);

  logic link_needed, low_pwr_off, pin_off;
  logic phy_want, mac_want;
  logic phy_seen, mac_seen;

  assign link_needed = (pwr_state == 2'b00) | wol_active | mng_uses_port | pme_en;
  assign low_pwr_off = cfg_lp_pd_en & ~link_needed;
  assign pin_off     = lan_off_pin & cfg_pin_pd;

  assign phy_want = cfg_valid & (low_pwr_off | serdes_mode | pin_off | cfg_port_off);
  assign mac_want = cfg_valid & pin_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phy_seen   <= 1'b0;
      mac_seen   <= 1'b0;
      phy_pd_req <= 1'b0;
      mac_pd_req <= 1'b0;
    end else begin
      phy_seen   <= phy_want;
      mac_seen   <= mac_want;
      phy_pd_req <= phy_want & phy_seen & (phy_pd_req | ~phy_dn_ack);
      mac_pd_req <= mac_want & mac_seen;
    end
  end

endmodule

module phy_pd_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_valid,
  input logic [1:0] pwr_state,
  input logic       wol_active,
  input logic       mng_uses_port,
  input logic       pme_en,
  input logic       serdes_mode,
  input logic       lan_off_pin,
  input logic       cfg_lp_pd_en,
  input logic       cfg_pin_pd,
  input logic       cfg_port_off,
  input logic       phy_dn_ack,
  input logic       phy_pd_req,
  input logic       mac_pd_req
);
  logic pcond, mcond;
  assign pcond = cfg_valid & (serdes_mode | cfg_port_off | (lan_off_pin & cfg_pin_pd) |
                 (cfg_lp_pd_en & (pwr_state != 2'b00) & ~wol_active & ~mng_uses_port & ~pme_en));
  assign mcond = cfg_valid & lan_off_pin & cfg_pin_pd;

  a_r1_idle_until_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_valid |=> (!phy_pd_req && !mac_pd_req));
  a_r9_phy_release: assert property (@(posedge clk) disable iff (!rst_n)
    !pcond |=> !phy_pd_req);
  a_r9_mac_release: assert property (@(posedge clk) disable iff (!rst_n)
    !mcond |=> !mac_pd_req);
  a_r8_phy_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(phy_pd_req) |-> ($past(pcond, 1) && $past(pcond, 2)));
  a_r8_mac_two_edges: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mac_pd_req) |-> ($past(mcond, 1) && $past(mcond, 2)));
  a_r10_wait_powerup: assert property (@(posedge clk) disable iff (!rst_n)
    (!phy_pd_req && phy_dn_ack) |=> !phy_pd_req);
  a_r11_mac_pin_only: assert property (@(posedge clk) disable iff (!rst_n)
    mac_pd_req |-> $past(lan_off_pin && cfg_pin_pd));
endmodule

bind phy_pd_ctrl phy_pd_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .pwr_state(pwr_state),
  .wol_active(wol_active), .mng_uses_port(mng_uses_port), .pme_en(pme_en),
  .serdes_mode(serdes_mode), .lan_off_pin(lan_off_pin), .cfg_lp_pd_en(cfg_lp_pd_en),
  .cfg_pin_pd(cfg_pin_pd), .cfg_port_off(cfg_port_off), .phy_dn_ack(phy_dn_ack),
  .phy_pd_req(phy_pd_req), .mac_pd_req(mac_pd_req)
);

// File: tb/tb_phy_pd_ctrl.sv
module tb_phy_pd_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_valid = 0, wol = 0, mng = 0, pme = 0, serdes = 0, pin = 0;
  logic lp_en = 0, pin_pd = 0, port_off = 0, bus_off = 0, ack = 0;
  logic [1:0] pst = 2'b00;
  logic phy_req, mac_req;
  int tests = 0, fails = 0;
  logic ex_phy = 0, ex_mac = 0, ex_ps = 0, ex_ms = 0;
  bit done = 0;

  always #2 clk = ~clk;

  phy_pd_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .pwr_state(pst),
    .wol_active(wol), .mng_uses_port(mng), .pme_en(pme), .serdes_mode(serdes),
    .lan_off_pin(pin), .cfg_lp_pd_en(lp_en), .cfg_pin_pd(pin_pd),
    .cfg_port_off(port_off), .cfg_bus_off(bus_off), .phy_dn_ack(ack),
    .phy_pd_req(phy_req), .mac_pd_req(mac_req));

  function automatic logic phy_cond();
    logic lp;
    lp = lp_en && pst != 2'b00 && !wol && !mng && !pme;
    return cfg_valid && (lp || serdes || port_off || (pin && pin_pd));
  endfunction

  function automatic logic mac_cond();
    return cfg_valid && pin && pin_pd;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_phy <= 0; ex_mac <= 0; ex_ps <= 0; ex_ms <= 0;
    end else begin
      ex_phy <= phy_cond() && ex_ps && (ex_phy || !ack);
      ex_mac <= mac_cond() && ex_ms;
      ex_ps  <= phy_cond();
      ex_ms  <= mac_cond();
    end
  end

  task automatic chk(string tag, logic ep, logic em);
    tests++;
    if (phy_req !== ep || mac_req !== em) begin
      fails++;
      $display("FAIL %s: phy=%b mac=%b expected phy=%b mac=%b", tag, phy_req, mac_req, ep, em);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear();
    wol = 0; mng = 0; pme = 0; serdes = 0; pin = 0; lp_en = 0;
    pin_pd = 0; port_off = 0; bus_off = 0; ack = 0; pst = 2'b00;
    tick(2);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd11));
    serdes = 1;
    tick(3);
    chk("R1 in reset", 0, 0);
    rst_n = 1;
    tick(4);
    chk("R1 cfg_valid low", 0, 0);
    cfg_valid = 1;
    tick(1); chk("R8 one edge only", 0, 0);
    tick(1); chk("R4 serdes", 1, 0);
    chk("R11 serdes leaves mac", 1, 0);
    serdes = 0; ack = 1;
    tick(1); chk("R9 release", 0, 0);
    serdes = 1;
    tick(3); chk("R10 ack still high", 0, 0);
    ack = 0;
    tick(1); chk("R10 rearm after powerup ack", 1, 0);
    ack = 1;
    tick(1); chk("R10 held while ack", 1, 0);
    serdes = 1; wol = 1; mng = 1; pme = 1; pst = 2'b00;
    tick(1); chk("R4 serdes with clients", 1, 0);
    clear();

    lp_en = 1; pst = 2'b11;
    tick(2); chk("R2 low power down", 1, 0);
    wol = 1; tick(1); chk("R3 wol keeps link", 0, 0);
    wol = 0; mng = 1; tick(2); chk("R3 mng keeps link", 0, 0);
    mng = 0; pme = 1; tick(2); chk("R3 pme keeps link", 0, 0);
    pme = 0; pst = 2'b00; tick(2); chk("R3 full power", 0, 0);
    pst = 2'b01; lp_en = 0; tick(2); chk("R3 lp enable off", 0, 0);
    lp_en = 1; tick(2); chk("R2 state 01", 1, 0);
    clear();

    pin = 1; pin_pd = 0; tick(3); chk("R5 pin unqualified", 0, 0);
    pin_pd = 1; tick(1); chk("R8 pin one edge", 0, 0);
    tick(1); chk("R5 pin qualified", 1, 1);
    pin = 0; tick(1); chk("R9 pin release", 0, 0);
    clear();

    port_off = 1; tick(2); chk("R6 port off", 1, 0);
    chk("R11 port off mac", 1, 0);
    clear();

    bus_off = 1; tick(4); chk("R7 bus off alone", 0, 0);
    lp_en = 1; pst = 2'b10; wol = 1; tick(3); chk("R7 bus off with link need", 0, 0);
    clear();

    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      chk("R8 R9 R10 random", ex_phy, ex_mac);
      if ($urandom_range(0, 5) == 0) wol = ~wol;
      if ($urandom_range(0, 5) == 0) mng = ~mng;
      if ($urandom_range(0, 5) == 0) pme = ~pme;
      if ($urandom_range(0, 9) == 0) serdes = ~serdes;
      if ($urandom_range(0, 4) == 0) pin = ~pin;
      if ($urandom_range(0, 7) == 0) pin_pd = ~pin_pd;
      if ($urandom_range(0, 7) == 0) lp_en = ~lp_en;
      if ($urandom_range(0, 11) == 0) port_off = ~port_off;
      if ($urandom_range(0, 3) == 0) bus_off = ~bus_off;
      if ($urandom_range(0, 3) == 0) ack = ~ack;
      if ($urandom_range(0, 5) == 0) pst = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 40) == 0) cfg_valid = ~cfg_valid;
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule